// File: doc/BRIEF.md
# Interlaced Field Scan Timing Generator

This block produces the raster timing for an interlaced display one field at a time. It runs at the pixel clock. It drives an active-low horizontal sync, a data-enable strobe, a field flag and the read address of the frame-buffer line that goes with the current scan line. The frame buffer holds a progressive image. A field scans only the even lines of that image or only the odd lines. To do this, each field starts from a base address chosen by the field flag, and the address then moves forward by two strides per displayed line.

The two fields differ in length by one line. The odd field carries one extra blank line at its end, so that alternate fields sit half a frame apart and the line pairs interleave on the screen. The pixel fetch engine uses the line address to know where to read. Vertical sync and any analogue stage are built by other logic, from the field flag and the line timing.

With the default parameters a line is 864 clocks, made of 720 visible pixels and then 12 front-porch, 64 sync and 68 back-porch clocks. Each field has 288 visible lines followed by 24 blank lines, or 25 in the odd field, which gives 312 and 313 lines per field and 625 lines per field pair.

Top module: `ifs_scan_gen`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks. Counting from clock 0 of the line, `hsync_n` is 0 exactly for clocks H_ACTIVE+H_FP through H_ACTIVE+H_FP+H_SYNC-1 and is 1 for all other clocks.
- R2: `de` is 1 only for clocks 0 to H_ACTIVE-1 of lines 0 to V_ACTIVE-1 of a field. It is 0 for every clock of every blank line.
- R3: A field with `field`=0 lasts V_ACTIVE+V_BLANK lines. A field with `field`=1 lasts V_ACTIVE+V_BLANK+1 lines, so the extra blank line is appended to every second field.
- R4: `field` changes only at the boundary between the last clock of a field and clock 0 of the next field, and it toggles at each such boundary (0 is even lines, 1 is odd lines).
- R5: Throughout visible line v of a field with flag f, `line_addr` equals BASE_ADDR + (2v+f)·STRIDE. The first visible line is therefore at BASE_ADDR in field 0 and at BASE_ADDR+STRIDE in field 1, and each visible line after it is 2·STRIDE further on.
- R6: During the blank lines of a field, `line_addr` holds the address of that field's last visible line, BASE_ADDR + (2·(V_ACTIVE-1)+f)·STRIDE.
- R7: While `rst_n` is 0 at a clock edge, the block returns to clock 0 of line 0 of field 0, with `line_addr`=BASE_ADDR. The first clock after release is therefore a visible pixel, and the sequence restarts from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_n | output | 1 | Horizontal sync, low during the sync interval |
| de | output | 1 | Data enable, high on visible pixels of visible lines |
| field | output | 1 | Current field: 0 even lines, 1 odd lines |
| line_addr | output | ADDR_W | Frame-buffer address of the current line |

## Verification
Because the outputs are decoded straight from the counters, a wrong pixel count shows up on `hsync_n` or `de` within the same line. A wrong line count shows up as `de` rising on a line that should be blank, or staying low on a line that should be visible, within one line. A wrong field length or a wrong flag toggle is visible at the next field boundary: the field flag flips one line early or late, and every address in the following field then carries the wrong parity. An address that steps wrongly is caught on the next visible line, and the bench compares every clock of several whole field pairs against arithmetic expectations.

// File: rtl/ifs_pkg.sv
// Package: shared types for the interlaced field scan generator.
// Assumes: field parity is carried as a one-bit enumeration.
package ifs_pkg;

    typedef enum logic {
        FLD_EVEN = 1'b0,
        FLD_ODD  = 1'b1
    } fld_e;

    // Parity of the field that follows the given one.
    function automatic fld_e fld_next(input fld_e f);
        return (f == FLD_EVEN) ? FLD_ODD : FLD_EVEN;
    endfunction

endpackage

// File: rtl/ifs_line_timer.sv
// Module: horizontal pixel counter with sync and visible-region decode.
// Assumes: a line starts with visible pixels, followed by front porch,
// then sync, then back porch; the total is at least 2 clocks.
module ifs_line_timer #(
    parameter int H_ACTIVE = 720,
    parameter int H_FP     = 12,
    parameter int H_SYNC   = 64,
    parameter int H_BP     = 68,
    localparam int HT      = H_ACTIVE + H_FP + H_SYNC + H_BP,
    localparam int HW      = $clog2(HT)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic          line_end,
    output logic          h_visible,
    output logic          hsync_n
);

    localparam logic [HW-1:0] H_LAST    = HW'(HT - 1);
    localparam logic [HW-1:0] H_ACT_END = HW'(H_ACTIVE);
    localparam logic [HW-1:0] H_SY_BEG  = HW'(H_ACTIVE + H_FP);
    localparam logic [HW-1:0] H_SY_END  = HW'(H_ACTIVE + H_FP + H_SYNC);

    // Pixel position within the line, wrapping at the line total.
    always_ff @(posedge clk) begin
        if (!rst_n)        h_cnt <= '0;
        else if (line_end) h_cnt <= '0;
        else               h_cnt <= h_cnt + 1'b1;
    end

    // Decode line end, visible pixels and the active-low sync window.
    always_comb begin
        line_end  = (h_cnt == H_LAST);
        h_visible = (h_cnt < H_ACT_END);
        hsync_n   = !((h_cnt >= H_SY_BEG) && (h_cnt < H_SY_END));
    end

endmodule

// File: rtl/ifs_field_seq.sv
// Module: line counter and field parity; odd fields get one extra blank line.
// Assumes: line_end pulses for one clock on the last pixel of each line.
module ifs_field_seq
    import ifs_pkg::*;
#(
    parameter int V_ACTIVE = 288,
    parameter int V_BLANK  = 24,
    localparam int VW      = $clog2(V_ACTIVE + V_BLANK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    output logic [VW-1:0] v_cnt,
    output fld_e          fld,
    output logic          v_visible,
    output logic          field_end
);

    localparam logic [VW-1:0] V_LAST_EVEN = VW'(V_ACTIVE + V_BLANK - 1);
    localparam logic [VW-1:0] V_LAST_ODD  = VW'(V_ACTIVE + V_BLANK);
    localparam logic [VW-1:0] V_ACT_END   = VW'(V_ACTIVE);

    logic [VW-1:0] v_last;

    // Last line index of the current field depends on its parity.
    always_comb begin
        v_last    = (fld == FLD_ODD) ? V_LAST_ODD : V_LAST_EVEN;
        field_end = line_end && (v_cnt == v_last);
        v_visible = (v_cnt < V_ACT_END);
    end

    // Line position within the field, restarting at each field end.
    always_ff @(posedge clk) begin
        if (!rst_n)         v_cnt <= '0;
        else if (field_end) v_cnt <= '0;
        else if (line_end)  v_cnt <= v_cnt + 1'b1;
    end

    // Field parity flips when a field finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)         fld <= FLD_EVEN;
        else if (field_end) fld <= fld_next(fld);
    end

endmodule

// File: rtl/ifs_addr_step.sv
// Module: frame-buffer line address; parity-chosen start, double-stride step.
// Assumes: field_end implies line_end; the address wraps modulo 2**ADDR_W.
module ifs_addr_step
    import ifs_pkg::*;
#(
    parameter int          V_ACTIVE  = 288,
    parameter int          ADDR_W    = 32,
    parameter int unsigned BASE_ADDR = 0,
    parameter int unsigned STRIDE    = 2048,
    parameter int          VW        = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              field_end,
    input  fld_e              fld,
    input  logic [VW-1:0]     v_cnt,
    output logic [ADDR_W-1:0] line_addr
);

    localparam logic [ADDR_W-1:0] A_EVEN   = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_ODD    = ADDR_W'(BASE_ADDR + STRIDE);
    localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(2 * STRIDE);
    localparam logic [VW-1:0]     V_LASTVIS = VW'(V_ACTIVE - 1);

    // Reload at field end, step on visible lines, hold over blanking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_addr <= A_EVEN;
        else if (field_end)
            line_addr <= (fld_next(fld) == FLD_ODD) ? A_ODD : A_EVEN;
        else if (line_end && (v_cnt < V_LASTVIS))
            line_addr <= line_addr + A_STEP;
    end

endmodule

// File: rtl/ifs_scan_gen.sv
// Module: top of the interlaced field scan generator.
// Assumes: pixel-rate clock, synchronous active-low reset; outputs are
// decoded from counter state and change one clock after each edge.
module ifs_scan_gen
    import ifs_pkg::*;
#(
    parameter int          H_ACTIVE  = 720,
    parameter int          H_FP      = 12,
    parameter int          H_SYNC    = 64,
    parameter int          H_BP      = 68,
    parameter int          V_ACTIVE  = 288,
    parameter int          V_BLANK   = 24,
    parameter int          ADDR_W    = 32,
    parameter int unsigned BASE_ADDR = 0,
    parameter int unsigned STRIDE    = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              hsync_n,
    output logic              de,
    output logic              field,
    output logic [ADDR_W-1:0] line_addr
);

    localparam int HT = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int HW = $clog2(HT);
    localparam int VW = $clog2(V_ACTIVE + V_BLANK + 1);

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          line_end;
    logic          h_visible;
    logic          v_visible;
    logic          field_end;
    fld_e          fld;

    ifs_line_timer #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .line_end(line_end),
        .h_visible(h_visible), .hsync_n(hsync_n)
    );

    ifs_field_seq #(
        .V_ACTIVE(V_ACTIVE), .V_BLANK(V_BLANK)
    ) u_field (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .v_cnt(v_cnt),
        .fld(fld), .v_visible(v_visible), .field_end(field_end)
    );

    ifs_addr_step #(
        .V_ACTIVE(V_ACTIVE), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .STRIDE(STRIDE), .VW(VW)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .field_end(field_end),
        .fld(fld), .v_cnt(v_cnt), .line_addr(line_addr)
    );

    // Data enable needs both a visible pixel and a visible line.
    always_comb begin
        de    = h_visible && v_visible;
        field = (fld == FLD_ODD);
    end

endmodule

// File: rtl/ifs_scan_checker.sv
// Module: temporal checks on the scan generator, attached by bind.
// Assumes: it observes the top's ports and its internal h_cnt and v_cnt.
module ifs_scan_checker #(
    parameter int H_ACTIVE = 720,
    parameter int H_FP     = 12,
    parameter int H_SYNC   = 64,
    parameter int H_BP     = 68,
    parameter int V_ACTIVE = 288,
    parameter int V_BLANK  = 24,
    parameter int ADDR_W   = 32,
    localparam int HT      = H_ACTIVE + H_FP + H_SYNC + H_BP,
    localparam int HW      = $clog2(HT),
    localparam int VW      = $clog2(V_ACTIVE + V_BLANK + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsync_n,
    input logic              de,
    input logic              field,
    input logic [ADDR_W-1:0] line_addr,
    input logic [HW-1:0]     h_cnt,
    input logic [VW-1:0]     v_cnt
);

    localparam logic [HW-1:0] H_LAST   = HW'(HT - 1);
    localparam logic [HW-1:0] H_SY_BEG = HW'(H_ACTIVE + H_FP);
    localparam logic [VW-1:0] V_ACT    = VW'(V_ACTIVE);
    localparam logic [VW-1:0] V_EVEN_L = VW'(V_ACTIVE + V_BLANK - 1);
    localparam logic [VW-1:0] V_ODD_L  = VW'(V_ACTIVE + V_BLANK);

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt == H_LAST) |=> (h_cnt == '0));                           // R1
    AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> (h_cnt == H_SY_BEG));                         // R1
    AST_DE_BLANK_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (v_cnt >= V_ACT) |-> !de);                                       // R2
    AST_EVEN_FIELD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!field && v_cnt == V_EVEN_L && h_cnt == H_LAST)
            |=> (field && v_cnt == '0));                                 // R3
    AST_ODD_FIELD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (field && v_cnt == V_ODD_L && h_cnt == H_LAST)
            |=> (!field && v_cnt == '0));                                // R3
    AST_FIELD_FLIP_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (field != $past(field)) |-> (h_cnt == '0 && v_cnt == '0));      // R4
    AST_ADDR_STEADY_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt != '0) |-> $stable(line_addr));                           // R5
    AST_ADDR_HOLD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (v_cnt > V_ACT) |-> $stable(line_addr));                         // R6

endmodule

bind ifs_scan_gen ifs_scan_checker #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_BLANK(V_BLANK), .ADDR_W(ADDR_W)
) u_scan_chk (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .de(de), .field(field),
    .line_addr(line_addr), .h_cnt(h_cnt), .v_cnt(v_cnt)
);

// File: tb/ifs_scan_gen_test.sv
`timescale 1ns/1ps
// Bench: sweeps whole field pairs of a small raster, checking every clock.
module ifs_scan_gen_test;

    localparam int HA = 8, HFP = 2, HSY = 3, HBP = 3;
    localparam int VA = 4, VB = 3;
    localparam int AW = 16;
    localparam int BASE = 'h100, STR = 'h40;
    localparam int HT = HA + HFP + HSY + HBP;
    localparam int FL0 = VA + VB;
    localparam int FL1 = VA + VB + 1;
    localparam int PAIR = FL0 + FL1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hsync_n, de, field;
    logic [AW-1:0] line_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ifs_scan_gen #(
        .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HSY), .H_BP(HBP),
        .V_ACTIVE(VA), .V_BLANK(VB), .ADDR_W(AW),
        .BASE_ADDR(BASE), .STRIDE(STR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .de(de),
        .field(field), .line_addr(line_addr)
    );

    task automatic chk(input string tag, input int act, input int exp, input int k);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at clock %0d: actual %0h expected %0h", tag, k, act, exp);
        end
    endtask

    // Compare every output for n clocks starting at clock 0 after reset.
    task automatic sweep(input int n);
        for (int k = 0; k < n; k++) begin
            int h, ln, lp, f, v, exp_addr;
            h  = k % HT;
            ln = k / HT;
            lp = ln % PAIR;
            if (lp < FL0) begin f = 0; v = lp; end
            else          begin f = 1; v = lp - FL0; end
            chk("R1 hsync_n", int'(hsync_n),
                ((h >= HA + HFP) && (h < HA + HFP + HSY)) ? 0 : 1, k);
            chk("R2 de", int'(de), ((h < HA) && (v < VA)) ? 1 : 0, k);
            chk("R3/R4 field", int'(field), f, k);
            if (v < VA) exp_addr = BASE + (2 * v + f) * STR;
            else        exp_addr = BASE + (2 * (VA - 1) + f) * STR;
            chk(v < VA ? "R5 line_addr" : "R6 line_addr", int'(line_addr), exp_addr, k);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R7: reset state seen at the ports on the first clock after release.
        chk("R7 de", int'(de), 1, 0);
        chk("R7 hsync_n", int'(hsync_n), 1, 0);
        chk("R7 field", int'(field), 0, 0);
        chk("R7 line_addr", int'(line_addr), BASE, 0);
        // R1 to R6: three full field pairs, clock by clock.
        sweep(3 * PAIR * HT);
        // R7: reset in the middle of an odd field restarts at field 0.
        sweep(FL0 * HT + 2 * HT + 5);
        do_reset();
        chk("R7 field after mid reset", int'(field), 0, 0);
        chk("R7 line_addr after mid reset", int'(line_addr), BASE, 0);
        sweep(2 * PAIR * HT);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule